// File: doc/BRIEF.md
# Transmit Interrupt Delay Controller

This block sits beside a transmit DMA engine. It watches the stream of descriptor write-back events. Each event is a one-cycle strobe that carries two command flags: report-status and delay-enable. It also carries a marker for an empty descriptor, meaning the buffer address or the length is zero. From each event the block produces a descriptor-done pulse and decides how to interrupt. A report-status descriptor without delay-enable interrupts at once. A report-status descriptor with delay-enable reloads a countdown counter from a programmed delay value, and the interrupt follows when that counter runs out.

The countdown moves one step per tick of a tick-enable input. The tick can be divided down by a parameterised prescaler. A later delayed descriptor restarts the countdown. A plain report-status descriptor cancels any pending countdown. Interrupts are gated by an interrupt-enable input. The counter's live value is visible at the ports.

Top module: `txint_delay_ctrl`

## Requirements
- R1: An event with report-status=1, delay-enable=1 and a nonzero delay value D loads the counter so that `count_val` equals D in the cycle after the strobe, and no interrupt pulse is produced for that event.
- R2: A delayed event that arrives while a countdown is running reloads the counter with the current delay value, which discards the remaining count.
- R3: The tick that takes the counter from 1 to 0 produces a one-cycle `irq_pulse` in the following cycle, but only when `irq_en` is 1. When `irq_en` is 0, no interrupt pulse is ever produced.
- R4: An event with report-status=1 and delay-enable=0 produces `irq_pulse` in the cycle after the strobe when `irq_en` is 1. It also clears the counter to 0, so the cancelled countdown raises no later interrupt.
- R5: An event with report-status=0 has no effect, whatever its delay-enable flag: no done pulse, no interrupt, and the counter keeps its value.
- R6: `done_pulse` is high for exactly the cycle after each strobe that has report-status=1, whether or not delay-enable is set. The delay timer never holds it back.
- R7: An empty descriptor (`wb_empty`=1) still produces `done_pulse` when report-status=1, and produces none when report-status=0.
- R8: A delayed event while the delay value is 0 behaves as an immediate interrupt: `irq_pulse` follows in the next cycle when `irq_en` is 1, and the counter stays at 0.
- R9: With TICK_DIV=1 the counter drops by one on each cycle where `tick_en` is 1 and holds otherwise. At 0 it stays at 0 until the next load, and further ticks produce no interrupt.
- R10: When an immediate event and a countdown expiry fall in the same cycle, exactly one `irq_pulse` cycle results.
- R11: While the synchronous reset `rst` is high, the counter and both output pulses are cleared. They read 0 in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Countdown time-base tick |
| irq_en | input | 1 | Write-back interrupt enable |
| delay_val | input | CNT_W | Programmed delay, in ticks |
| wb_valid | input | 1 | One-cycle descriptor write-back strobe |
| wb_rs | input | 1 | Report-status flag of the event |
| wb_ide | input | 1 | Delay-enable flag of the event |
| wb_empty | input | 1 | Descriptor moved no data (zero address or length) |
| done_pulse | output | 1 | Descriptor-done status pulse |
| irq_pulse | output | 1 | Transmit interrupt pulse |
| count_val | output | CNT_W | Live countdown value |

## Verification
The delayed path is swept over every nonzero delay of a 4-bit counter with the enable both on and off. Counting the ticks up to the pulse separates an off-by-one expiry from a correct one, and the enable-off half exposes a missing gate. Directed patterns then cover the interrupt decision. A mid-count reload is distinguished from a simple continuation by the new count. A mid-count plain report-status event shows cancellation, because no later pulse appears. Report-status-clear events leave the count untouched, a zero delay collapses to an immediate pulse, and a coincident expiry and immediate event must give a single pulse. Empty descriptors and delayed descriptors both show whether the done pulse depends only on report-status.

// File: rtl/txint_pkg.sv
package txint_pkg;

   typedef enum logic [1:0] {
      WB_IGNORE    = 2'd0,
      WB_IMMEDIATE = 2'd1,
      WB_DELAYED   = 2'd2
   } wb_kind_e;

   typedef struct packed {
      logic     set_done;
      wb_kind_e kind;
   } wb_action_t;

endpackage

// File: rtl/txint_wb_classify.sv
module txint_wb_classify
   import txint_pkg::*;
(
   input  logic       wb_valid,
   input  logic       wb_rs,
   input  logic       wb_ide,
   input  logic       delay_zero,
   output wb_action_t action
);

   always_comb begin
      action.set_done = 1'b0;
      action.kind     = WB_IGNORE;
      if (wb_valid && wb_rs) begin
         action.set_done = 1'b1;
         if (wb_ide && !delay_zero) begin
            action.kind = WB_DELAYED;
         end else begin
            action.kind = WB_IMMEDIATE;
         end
      end
   end

endmodule

// File: rtl/txint_countdown.sv
module txint_countdown #(
   parameter int CNT_W    = 8,
   parameter int TICK_DIV = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick_en,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             cancel,
   output logic [CNT_W-1:0] count,
   output logic             expire
);

   localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

   logic             step;
   logic [CNT_W-1:0] count_q;

   generate
      if (TICK_DIV == 1) begin : g_direct
         assign step = tick_en;
      end else begin : g_prescale
         logic [DIV_W-1:0] div_q;
         logic             div_last;
         assign div_last = (div_q == DIV_W'(TICK_DIV - 1));
         assign step     = tick_en && div_last;
         always_ff @(posedge clk) begin
            if (rst || load || cancel) begin
               div_q <= '0;
            end else if (tick_en) begin
               div_q <= div_last ? '0 : div_q + 1'b1;
            end
         end
      end
   endgenerate

   assign expire = step && (count_q == CNT_W'(1));
   assign count  = count_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         count_q <= '0;
      end else if (cancel) begin
         count_q <= '0;
      end else if (load) begin
         count_q <= load_val;
      end else if (step && (count_q != '0)) begin
         count_q <= count_q - 1'b1;
      end
   end

   // R1 R2
   cnt_load_chk: assert property (@(posedge clk) disable iff (rst)
      load && !cancel |=> count_q == $past(load_val));

   // R4
   cnt_cancel_chk: assert property (@(posedge clk) disable iff (rst)
      cancel |=> count_q == '0);

   // R9
   cnt_hold_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (count_q == '0) && !load |=> count_q == '0);

   // R9
   cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !load && !cancel && !step |=> $stable(count_q));

endmodule

// File: rtl/txint_irq_merge.sv
module txint_irq_merge (
   input  logic clk,
   input  logic rst,
   input  logic irq_en,
   input  logic imm_req,
   input  logic expire,
   input  logic set_done,
   output logic irq_pulse,
   output logic done_pulse
);

   logic irq_q;
   logic done_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         irq_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         irq_q  <= irq_en && (imm_req || expire);
         done_q <= set_done;
      end
   end

   assign irq_pulse  = irq_q;
   assign done_pulse = done_q;

   // R3
   irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
      !irq_en |=> !irq_pulse);

   // R10
   irq_source_chk: assert property (@(posedge clk) disable iff (rst)
      !imm_req && !expire |=> !irq_pulse);

endmodule

// File: rtl/txint_delay_ctrl.sv
module txint_delay_ctrl
   import txint_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter int TICK_DIV = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick_en,
   input  logic             irq_en,
   input  logic [CNT_W-1:0] delay_val,
   input  logic             wb_valid,
   input  logic             wb_rs,
   input  logic             wb_ide,
   input  logic             wb_empty,
   output logic             done_pulse,
   output logic             irq_pulse,
   output logic [CNT_W-1:0] count_val
);

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("txint_delay_ctrl: CNT_W must lie in 2..32");
      end
      if (TICK_DIV < 1) begin : g_bad_div
         $error("txint_delay_ctrl: TICK_DIV must be at least 1");
      end
   endgenerate

   wb_action_t action;
   logic       delay_zero;
   logic       do_load;
   logic       do_imm;
   logic       expire;

   assign delay_zero = (delay_val == '0);

   txint_wb_classify u_classify (
      .wb_valid   (wb_valid),
      .wb_rs      (wb_rs),
      .wb_ide     (wb_ide),
      .delay_zero (delay_zero),
      .action     (action)
   );

   assign do_load = (action.kind == WB_DELAYED);
   assign do_imm  = (action.kind == WB_IMMEDIATE);

   txint_countdown #(
      .CNT_W    (CNT_W),
      .TICK_DIV (TICK_DIV)
   ) u_countdown (
      .clk      (clk),
      .rst      (rst),
      .tick_en  (tick_en),
      .load     (do_load),
      .load_val (delay_val),
      .cancel   (do_imm),
      .count    (count_val),
      .expire   (expire)
   );

   txint_irq_merge u_merge (
      .clk        (clk),
      .rst        (rst),
      .irq_en     (irq_en),
      .imm_req    (do_imm),
      .expire     (expire),
      .set_done   (action.set_done),
      .irq_pulse  (irq_pulse),
      .done_pulse (done_pulse)
   );

   // R6
   done_nodelay_chk: assert property (@(posedge clk) disable iff (rst)
      wb_valid && wb_rs |=> done_pulse);

   // R7
   empty_done_chk: assert property (@(posedge clk) disable iff (rst)
      wb_valid && wb_empty && !wb_rs |=> !done_pulse);

   // R5
   rs_clear_chk: assert property (@(posedge clk) disable iff (rst)
      wb_valid && !wb_rs && !tick_en |=> !done_pulse && $stable(count_val));

   // R8
   zero_delay_chk: assert property (@(posedge clk) disable iff (rst)
      wb_valid && wb_rs && wb_ide && (delay_val == '0) && irq_en |=> irq_pulse && (count_val == '0));

   // R1
   delayed_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      wb_valid && wb_rs && wb_ide && (delay_val != '0) && !tick_en |=> !irq_pulse);

endmodule

// File: tb/test_txint_delay_ctrl.sv
module test_txint_delay_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int W          = 4;

   logic         clk = 1'b0;
   logic         rst;
   logic         tick_en;
   logic         irq_en;
   logic [W-1:0] delay_val;
   logic         wb_valid;
   logic         wb_rs;
   logic         wb_ide;
   logic         wb_empty;
   logic         done_pulse;
   logic         irq_pulse;
   logic [W-1:0] count_val;

   int n_checks = 0;
   int n_fails  = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   txint_delay_ctrl #(.CNT_W(W), .TICK_DIV(1)) i_txint_delay_ctrl (
      .clk        (clk),
      .rst        (rst),
      .tick_en    (tick_en),
      .irq_en     (irq_en),
      .delay_val  (delay_val),
      .wb_valid   (wb_valid),
      .wb_rs      (wb_rs),
      .wb_ide     (wb_ide),
      .wb_empty   (wb_empty),
      .done_pulse (done_pulse),
      .irq_pulse  (irq_pulse),
      .count_val  (count_val)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wb(input logic rs, input logic ide, input logic empty);
      wb_valid = 1'b1;
      wb_rs    = rs;
      wb_ide   = ide;
      wb_empty = empty;
      step();
      wb_valid = 1'b0;
      wb_rs    = 1'b0;
      wb_ide   = 1'b0;
      wb_empty = 1'b0;
   endtask

   task automatic tick();
      tick_en = 1'b1;
      step();
      tick_en = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      rst = 1'b1; tick_en = 1'b0; irq_en = 1'b0; delay_val = '0;
      wb_valid = 1'b0; wb_rs = 1'b0; wb_ide = 1'b0; wb_empty = 1'b0;
      @(negedge clk);
      step();
      rst = 1'b0;
      // R11 reset state
      chk("R11", "count", int'(count_val), 0);
      chk("R11", "irq", int'(irq_pulse), 0);
      chk("R11", "done", int'(done_pulse), 0);

      // R1 R3 R9 sweep of every nonzero delay, enable on and off
      for (int en = 0; en < 2; en++) begin
         for (int d = 1; d < (1 << W); d++) begin
            irq_en    = en[0];
            delay_val = W'(d);
            wb(1'b1, 1'b1, 1'b0);
            chk("R1", "count after load", int'(count_val), d);
            chk("R1", "no irq on load", int'(irq_pulse), 0);
            chk("R6", "done on delayed", int'(done_pulse), 1);
            step();
            chk("R9", "hold without tick", int'(count_val), d);
            for (int k = 1; k <= d; k++) begin
               tick();
               chk("R9", "count per tick", int'(count_val), d - k);
               chk("R3", "irq at expiry", int'(irq_pulse), (k == d) ? en : 0);
            end
            tick();
            chk("R9", "stays zero", int'(count_val), 0);
            chk("R9", "no irq at zero", int'(irq_pulse), 0);
         end
      end

      // R8 zero delay acts immediately
      for (int en = 0; en < 2; en++) begin
         irq_en    = en[0];
         delay_val = '0;
         wb(1'b1, 1'b1, 1'b0);
         chk("R8", "irq", int'(irq_pulse), en);
         chk("R8", "count", int'(count_val), 0);
         chk("R6", "done", int'(done_pulse), 1);
      end

      // R4 cancellation by plain report-status
      irq_en    = 1'b1;
      delay_val = 4'd9;
      wb(1'b1, 1'b1, 1'b0);
      repeat (3) tick();
      chk("R4", "count before cancel", int'(count_val), 6);
      wb(1'b1, 1'b0, 1'b0);
      chk("R4", "immediate irq", int'(irq_pulse), 1);
      chk("R4", "counter cleared", int'(count_val), 0);
      chk("R6", "done", int'(done_pulse), 1);
      for (int k = 0; k < 12; k++) begin
         tick();
         chk("R4", "no late irq", int'(irq_pulse), 0);
      end
      irq_en = 1'b0;
      wb(1'b1, 1'b0, 1'b0);
      chk("R3", "immediate gated", int'(irq_pulse), 0);
      irq_en = 1'b1;

      // R2 reload while counting
      delay_val = 4'd6;
      wb(1'b1, 1'b1, 1'b0);
      repeat (2) tick();
      chk("R2", "count mid", int'(count_val), 4);
      delay_val = 4'd11;
      wb(1'b1, 1'b1, 1'b0);
      chk("R2", "reloaded", int'(count_val), 11);
      chk("R2", "no irq", int'(irq_pulse), 0);
      for (int k = 0; k < 10; k++) begin
         tick();
         chk("R2", "no early irq", int'(irq_pulse), 0);
      end
      tick();
      chk("R2", "irq after full reload", int'(irq_pulse), 1);

      // R5 report-status clear has no effect
      delay_val = 4'd5;
      wb(1'b1, 1'b1, 1'b0);
      tick();
      wb(1'b0, 1'b1, 1'b0);
      chk("R5", "count kept", int'(count_val), 4);
      chk("R5", "no done", int'(done_pulse), 0);
      chk("R5", "no irq", int'(irq_pulse), 0);
      wb(1'b0, 1'b0, 1'b0);
      chk("R5", "count kept plain", int'(count_val), 4);
      chk("R5", "no irq plain", int'(irq_pulse), 0);

      // R7 empty descriptors
      wb(1'b1, 1'b0, 1'b1);
      chk("R7", "empty done", int'(done_pulse), 1);
      wb(1'b0, 1'b0, 1'b1);
      chk("R7", "empty no rs", int'(done_pulse), 0);
      wb(1'b1, 1'b1, 1'b1);
      chk("R7", "empty delayed done", int'(done_pulse), 1);
      chk("R7", "empty delayed load", int'(count_val), 5);
      step();
      chk("R6", "done one cycle", int'(done_pulse), 0);

      // R10 coincident expiry and immediate event
      delay_val = 4'd3;
      wb(1'b1, 1'b1, 1'b0);
      repeat (2) tick();
      chk("R10", "count at one", int'(count_val), 1);
      tick_en = 1'b1;
      wb(1'b1, 1'b0, 1'b0);
      tick_en = 1'b0;
      chk("R10", "single irq", int'(irq_pulse), 1);
      chk("R10", "count zero", int'(count_val), 0);
      step();
      chk("R10", "pulse ends", int'(irq_pulse), 0);

      // R11 reset mid-count
      delay_val = 4'd7;
      wb(1'b1, 1'b1, 1'b0);
      rst = 1'b1;
      step();
      rst = 1'b0;
      chk("R11", "count cleared", int'(count_val), 0);
      chk("R11", "irq cleared", int'(irq_pulse), 0);
      chk("R11", "done cleared", int'(done_pulse), 0);
      repeat (8) tick();
      chk("R11", "no irq after reset", int'(irq_pulse), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

endmodule